// File: doc/BRIEF.md
# Gated clock enable controller

This block decides, from software-written control registers and a low-power HALT request, which peripheral clocks of a small system-on-chip run. It serves seven destinations: the LCD interface, the LCD memory bus port, the SDRAM controller's CPU-side and LCD-side bus ports, the SDRAM register port, the SDRAM interface, and the static-memory controller. Each destination receives a copy of the main clock through a latch-based gate, which cannot produce a runt pulse.

Two gating registers and one divider register sit on a simple 32-bit register bus. Some bits switch a clock on or off outright. Others only choose whether a clock that normally runs is dropped during HALT. One clock is the OR of two enables. The 4-bit LCD divider value is locked while the LCD interface clock runs. A blocked write leaves the divider unchanged and sets a sticky error flag, which software clears by writing 1 to it.

A two-state power-mode machine tracks HALT. It has the states `PM_RUN` and `PM_HALT`. The transition ENTER (`PM_RUN` to `PM_HALT`) is taken when `halt_i` is 1 at a rising edge. The transition WAKE (`PM_HALT` to `PM_RUN`) is taken when `halt_i` is 0 at a rising edge. In every other case the machine stays in its current state.

Top module: `gclk_en_ctrl`

## Requirements
- R1: After an active-low synchronous reset, offset 0x00 reads 0x00000000, offset 0x04 reads 0x14000000 and offset 0x08 reads 0x00000000. `lcd_div_o` is 0. Only `gclk_o[1]` and `gclk_o[6]` run. The clock indices are: 0 LCD interface, 1 LCD bus, 2 SDRAM CPU port, 3 SDRAM LCD port, 4 SDRAM register port, 5 SDRAM interface, 6 static-memory controller.
- R2: Offset 0x00 bit 0 switches `gclk_o[0]` and bit 4 switches `gclk_o[4]`. In both cases 1 supplies the clock and 0 stops it, whatever the HALT state.
- R3: A write to offset 0x08 while bit 0 of offset 0x00 is 0 loads bits 19:16 into the divider. The divider appears on `lcd_div_o` and reads back at bits 19:16.
- R4: A write to offset 0x08 while bit 0 of offset 0x00 is 1 leaves the divider unchanged and sets the error flag at bit 31 of offset 0x08.
- R5: A write to offset 0x08 with bit 31 set, made while bit 0 of offset 0x00 is 0, clears the error flag.
- R6: `gclk_o[1]` runs whenever the state is `PM_RUN`. In `PM_HALT` it stops exactly when offset 0x04 bit 28 is 0.
- R7: Offset 0x00 bit 6 switches `gclk_o[2]`. In `PM_HALT` that clock is stopped unless offset 0x00 bit 7 is 1.
- R8: Offset 0x00 bit 5 switches `gclk_o[3]`, and HALT has no effect on it.
- R9: `gclk_o[5]` runs whenever offset 0x00 bit 6 or bit 5 is 1, in either state.
- R10: `gclk_o[6]` runs whenever the state is `PM_RUN`. In `PM_HALT` it stops exactly when offset 0x04 bit 28 is replaced by bit 26, that is, it stops exactly when offset 0x04 bit 26 is 0.
- R11: Unused register bits read 0 and ignore writes. An unmapped offset reads 0, and writes to it change nothing.
- R12: A register write or a `halt_i` change captured at rising edge N reaches the gated clocks in the high phase after edge N+1. Until then the old gating holds through the high phase after edge N. Every gated clock is low while `clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_i | input | 1 | HALT request, sampled on the rising edge |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| lcd_div_o | output | DIV_W | Current LCD divider value |
| gclk_o | output | 7 | Gated clocks, indexed as in R1 |

## Verification
The bench builds the block with its defaults: `ADDR_W` = 4, `DIV_W` = 4 and `DIV_LSB` = 16. These values put all three registers and the unmapped offset 0x0C on the bus, and they place the divider field at bits 19:16, next to the error flag at bit 31. The gated clocks are sampled in both clock phases. This makes visible the one-phase delay of the latched enables around ENTER and WAKE, and it shows that no clock is high while the main clock is low.

// File: rtl/gce_pkg.sv
`timescale 1ns/1ps
package gce_pkg;
    localparam int NCLK        = 7;
    localparam int CK_LCD_IF   = 0;
    localparam int CK_LCD_BUS  = 1;
    localparam int CK_SDC_CPU  = 2;
    localparam int CK_SDC_LCD  = 3;
    localparam int CK_SDC_REG  = 4;
    localparam int CK_SDRAM_IF = 5;
    localparam int CK_SMC      = 6;

    localparam int OFS_GATE0 = 0;
    localparam int OFS_GATE1 = 4;
    localparam int OFS_DIV   = 8;

    localparam int B_LCD_IF     = 0;
    localparam int B_SDC_REG    = 4;
    localparam int B_SDC_LCD    = 5;
    localparam int B_SDC_CPU    = 6;
    localparam int B_SDC_CPU_HK = 7;
    localparam int B_SMC_HK     = 26;
    localparam int B_LCDBUS_HK  = 28;
    localparam int B_DIV_ERR    = 31;

    typedef enum logic {
        PM_RUN  = 1'b0,
        PM_HALT = 1'b1
    } pm_state_t;
endpackage

// File: rtl/gce_regs.sv
`timescale 1ns/1ps
module gce_regs
    import gce_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DIV_W   = 4,
    parameter int DIV_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              lcd_if_en,
    output logic              sdc_reg_en,
    output logic              sdc_lcd_en,
    output logic              sdc_cpu_en,
    output logic              sdc_cpu_hkeep,
    output logic              smc_hkeep,
    output logic              lcdbus_hkeep,
    output logic [DIV_W-1:0]  lcd_div,
    output logic              div_err
);
    localparam logic [ADDR_W-1:0] A_G0  = ADDR_W'(OFS_GATE0);
    localparam logic [ADDR_W-1:0] A_G1  = ADDR_W'(OFS_GATE1);
    localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(OFS_DIV);

    logic wr_g0, wr_g1, wr_div;
    logic unused_wdata;

    assign wr_g0  = bus_wr && (bus_addr == A_G0);
    assign wr_g1  = bus_wr && (bus_addr == A_G1);
    assign wr_div = bus_wr && (bus_addr == A_DIV);
    assign unused_wdata = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcd_if_en     <= 1'b0;
            sdc_reg_en    <= 1'b0;
            sdc_lcd_en    <= 1'b0;
            sdc_cpu_en    <= 1'b0;
            sdc_cpu_hkeep <= 1'b0;
            smc_hkeep     <= 1'b1;
            lcdbus_hkeep  <= 1'b1;
            lcd_div       <= '0;
            div_err       <= 1'b0;
        end else begin
            if (wr_g0) begin
                lcd_if_en     <= bus_wdata[B_LCD_IF];
                sdc_reg_en    <= bus_wdata[B_SDC_REG];
                sdc_lcd_en    <= bus_wdata[B_SDC_LCD];
                sdc_cpu_en    <= bus_wdata[B_SDC_CPU];
                sdc_cpu_hkeep <= bus_wdata[B_SDC_CPU_HK];
            end
            if (wr_g1) begin
                smc_hkeep    <= bus_wdata[B_SMC_HK];
                lcdbus_hkeep <= bus_wdata[B_LCDBUS_HK];
            end
            if (wr_div) begin
                if (lcd_if_en) begin
                    div_err <= 1'b1;
                end else begin
                    lcd_div <= bus_wdata[DIV_LSB +: DIV_W];
                    if (bus_wdata[B_DIV_ERR]) begin
                        div_err <= 1'b0;
                    end
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_G0) begin
            bus_rdata[B_LCD_IF]     = lcd_if_en;
            bus_rdata[B_SDC_REG]    = sdc_reg_en;
            bus_rdata[B_SDC_LCD]    = sdc_lcd_en;
            bus_rdata[B_SDC_CPU]    = sdc_cpu_en;
            bus_rdata[B_SDC_CPU_HK] = sdc_cpu_hkeep;
        end else if (bus_addr == A_G1) begin
            bus_rdata[B_SMC_HK]    = smc_hkeep;
            bus_rdata[B_LCDBUS_HK] = lcdbus_hkeep;
        end else if (bus_addr == A_DIV) begin
            bus_rdata[DIV_LSB +: DIV_W] = lcd_div;
            bus_rdata[B_DIV_ERR]        = div_err;
        end
    end

    // R3
    div_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_div && !lcd_if_en) |=> (lcd_div == $past(bus_wdata[DIV_LSB +: DIV_W])));
    // R4
    div_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lcd_if_en) |-> $stable(lcd_div));
    // R4
    div_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_div && lcd_if_en) |=> div_err);
    // R5
    div_err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_div && !lcd_if_en && bus_wdata[B_DIV_ERR]) |=> !div_err);
endmodule

// File: rtl/gce_pm_fsm.sv
`timescale 1ns/1ps
module gce_pm_fsm
    import gce_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_i,
    output logic in_halt
);
    pm_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RUN:  if (halt_i)  state_d = PM_HALT;
            PM_HALT: if (!halt_i) state_d = PM_RUN;
            default: state_d = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PM_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        in_halt = 1'b0;
        unique case (state_q)
            PM_RUN:  in_halt = 1'b0;
            PM_HALT: in_halt = 1'b1;
            default: in_halt = 1'b0;
        endcase
    end
endmodule

// File: rtl/gce_clk_gate.sv
`timescale 1ns/1ps
module gce_clk_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);
    logic en_q;

    always_latch begin
        if (!clk_i) en_q <= en_i;
    end

    assign gclk_o = clk_i & en_q;
endmodule

// File: rtl/gclk_en_ctrl.sv
`timescale 1ns/1ps
module gclk_en_ctrl
    import gce_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DIV_W   = 4,
    parameter int DIV_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [DIV_W-1:0]  lcd_div_o,
    output logic [NCLK-1:0]   gclk_o
);
    logic lcd_if_en, sdc_reg_en, sdc_lcd_en, sdc_cpu_en;
    logic sdc_cpu_hkeep, smc_hkeep, lcdbus_hkeep, div_err;
    logic in_halt;
    logic [NCLK-1:0] en_vec;

    gce_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .DIV_LSB(DIV_LSB)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .lcd_if_en(lcd_if_en), .sdc_reg_en(sdc_reg_en),
        .sdc_lcd_en(sdc_lcd_en), .sdc_cpu_en(sdc_cpu_en),
        .sdc_cpu_hkeep(sdc_cpu_hkeep), .smc_hkeep(smc_hkeep),
        .lcdbus_hkeep(lcdbus_hkeep), .lcd_div(lcd_div_o), .div_err(div_err)
    );

    gce_pm_fsm pm_i (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .in_halt(in_halt)
    );

    always_comb begin
        en_vec              = '0;
        en_vec[CK_LCD_IF]   = lcd_if_en;
        en_vec[CK_LCD_BUS]  = !in_halt || lcdbus_hkeep;
        en_vec[CK_SDC_CPU]  = sdc_cpu_en && (!in_halt || sdc_cpu_hkeep);
        en_vec[CK_SDC_LCD]  = sdc_lcd_en;
        en_vec[CK_SDC_REG]  = sdc_reg_en;
        en_vec[CK_SDRAM_IF] = sdc_cpu_en || sdc_lcd_en;
        en_vec[CK_SMC]      = !in_halt || smc_hkeep;
    end

    for (genvar g = 0; g < NCLK; g++) begin : g_gate
        gce_clk_gate gate_i (.clk_i(clk), .en_i(en_vec[g]), .gclk_o(gclk_o[g]));
    end

    logic unused_err;
    assign unused_err = div_err;

    // R6
    lcdbus_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(halt_i) |-> en_vec[CK_LCD_BUS]);
    // R10
    smc_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(halt_i) |-> en_vec[CK_SMC]);
    // R7
    sdc_cpu_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(halt_i) && !sdc_cpu_hkeep) |-> !en_vec[CK_SDC_CPU]);
    // R9
    sdram_if_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec[CK_SDC_LCD] || sdc_cpu_en) |-> en_vec[CK_SDRAM_IF]);
endmodule

// File: tb/gclk_en_ctrl_tb_top.sv
`timescale 1ns/1ps
module gclk_en_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt_i = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  lcd_div_o;
    logic [6:0]  gclk_o;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    gclk_en_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .lcd_div_o(lcd_div_o), .gclk_o(gclk_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    // sample in the high phase after the next rising edge
    task automatic clk_chk(input string req, input logic [6:0] exp);
        @(posedge clk); #1;
        chk(req, {25'b0, gclk_o}, {25'b0, exp});
    endtask

    task automatic set_halt(input logic v, input logic [6:0] old_v, input logic [6:0] new_v);
        @(negedge clk);
        halt_i = v;
        clk_chk("R12 old gating after capture edge", old_v);
        clk_chk("R12 new gating one edge later", new_v);
    endtask

    task automatic t_reset();
        rd_chk("R1 gate0 reset", 4'h0, 32'h0000_0000);
        rd_chk("R1 gate1 reset", 4'h4, 32'h1400_0000);
        rd_chk("R1 div reset", 4'h8, 32'h0000_0000);
        chk("R1 divider out", {28'b0, lcd_div_o}, 32'h0);
        clk_chk("R1 reset clocks", 7'h42);
    endtask

    task automatic t_plain();
        wr(4'h0, 32'h0000_0001); clk_chk("R2 LCD interface on", 7'h43);
        wr(4'h0, 32'h0000_0010); clk_chk("R2 SDRAM register port on", 7'h52);
        wr(4'h0, 32'h0000_0020); clk_chk("R8 R9 SDRAM LCD port and interface", 7'h6A);
        wr(4'h0, 32'h0000_0000); clk_chk("R2 all plain clocks off", 7'h42);
    endtask

    task automatic t_unused();
        wr(4'h0, 32'hFFFF_FFFF);
        rd_chk("R11 gate0 unused bits", 4'h0, 32'h0000_00F1);
        clk_chk("R2 R9 all clocks on", 7'h7F);
        @(negedge clk); #1;
        chk("R12 low phase gated clocks", {25'b0, gclk_o}, 32'h0);
        wr(4'h0, 32'h0000_0000);
        wr(4'h4, 32'hFFFF_FFFF);
        rd_chk("R11 gate1 unused bits", 4'h4, 32'h1400_0000);
        wr(4'hC, 32'hFFFF_FFFF);
        rd_chk("R11 unmapped reads 0", 4'hC, 32'h0);
        rd_chk("R11 unmapped write ignored", 4'h0, 32'h0);
        clk_chk("R11 clocks unchanged", 7'h42);
        wr(4'h8, 32'hFFFF_FFFF);
        rd_chk("R11 R5 div unused bits", 4'h8, 32'h000F_0000);
    endtask

    task automatic t_div();
        wr(4'h8, 32'h000A_0000);
        rd_chk("R3 divider loaded", 4'h8, 32'h000A_0000);
        chk("R3 divider out", {28'b0, lcd_div_o}, 32'hA);
        wr(4'h0, 32'h0000_0001);
        wr(4'h8, 32'h0005_0000);
        rd_chk("R4 locked write blocked, flag set", 4'h8, 32'h800A_0000);
        chk("R4 divider out unchanged", {28'b0, lcd_div_o}, 32'hA);
        wr(4'h8, 32'h8000_0000);
        rd_chk("R4 R5 clear blocked while locked", 4'h8, 32'h800A_0000);
        wr(4'h0, 32'h0000_0000);
        wr(4'h8, 32'h8003_0000);
        rd_chk("R5 flag cleared, divider loaded", 4'h8, 32'h0003_0000);
    endtask

    task automatic t_halt();
        wr(4'h0, 32'h0000_0060);
        clk_chk("R7 R8 run with both SDRAM ports", 7'h6E);
        set_halt(1'b1, 7'h6E, 7'h6A);
        wr(4'h4, 32'h0000_0000);
        clk_chk("R6 R10 halt stops LCD bus and static memory", 7'h28);
        wr(4'h0, 32'h0000_00E0);
        clk_chk("R7 CPU port kept in halt", 7'h2C);
        wr(4'h0, 32'h0000_0070);
        clk_chk("R2 R7 register port runs in halt", 7'h38);
        set_halt(1'b0, 7'h38, 7'h7E);
        wr(4'h4, 32'h1400_0000);
        wr(4'h0, 32'h0000_0000);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_unused();
        t_div();
        t_halt();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule